// File: doc/BRIEF.md
# SHA-512 Two-Round Compression Unit

This unit advances the SHA-512 working state by two compression rounds per operation. The eight 64-bit working words travel in two 256-bit vectors. One vector carries the pair groups A, B, E, F and the other carries C, D, G, H. A 128-bit operand supplies the two round inputs WK0 and WK1. Each of these is a message word already added to its round constant. The unit returns only the new A, B, E, F vector.

Two rounds shift every word by two places, so the new C, D, G, H equal the old A, B, E, F. The caller therefore hands the vector it just supplied as the first operand back in as the second operand of the next call. Message scheduling, round-constant lookup and the final hash addition belong to other blocks.

A parameter picks the implementation. The iterative variant takes two clocks, one round per clock, and uses a valid/ready handshake. The combinational variant gives the result in the same cycle.

Top module: `sha512_dual_round`

## Requirements
- R1: In `abef_in`, A is bits 255:192, B is bits 191:128, E is bits 127:64 and F is bits 63:0.
- R2: In `cdgh_in`, C is bits 255:192, D is bits 191:128, G is bits 127:64 and H is bits 63:0.
- R3: WK0 is `wk_in[63:0]` and WK1 is `wk_in[127:64]`. The first round uses WK0 and the second round uses WK1.
- R4: A round forms T = CH(E,F,G) + S1(E) + WK + H. The new A is T + MAJ(A,B,C) + S0(A) and the new E is T + D. Every addition wraps modulo 2^64.
- R5: A round moves the other words along by one place: the new B is the old A, the new C is the old B, the new D is the old C, the new F is the old E, the new G is the old F and the new H is the old G.
- R6: S0(x) XORs x rotated right by 28, 34 and 39. S1(x) XORs x rotated right by 14, 18 and 41.
- R7: MAJ(a,b,c) = (a&b)^(a&c)^(b&c), and CH(e,f,g) = (e&f)^(~e&g).
- R8: `out_abef` holds the state after exactly two rounds, packed in the R1 layout.
- R9: In the iterative variant (ITERATIVE=1), an operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `busy` is then high for exactly two clocks, and `in_ready` is low whenever `busy` is high. `in_valid` has no effect while `busy` is high.
- R10: In the iterative variant, `out_valid` is a one-cycle pulse in the clock after the second round. `out_abef` then holds its value until the next accept.
- R11: A synchronous active-high `rst` clears `busy` and `out_valid`. This cancels an operation in flight, and after reset `in_ready` is high.
- R12: In the combinational variant (ITERATIVE=0), `in_ready` is always 1, `busy` is always 0, `out_valid` equals `in_valid`, and `out_abef` is the R8 result in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are present |
| in_ready | output | 1 | The unit can accept an operation |
| abef_in | input | 256 | Working words A, B, E, F |
| cdgh_in | input | 256 | Working words C, D, G, H |
| wk_in | input | 128 | WK1 in the upper half, WK0 in the lower half |
| busy | output | 1 | Rounds in progress |
| out_valid | output | 1 | The result is valid |
| out_abef | output | 256 | A, B, E, F after two rounds |

## Verification
The checker watches the handshake on every cycle. It checks that `in_ready` is low while `busy` is high, and that an accept is followed by two busy clocks and then a single `out_valid` pulse. It also checks that the output holds while the unit is idle, that reset clears the control state, and that the combinational variant passes `in_valid` straight through. The arithmetic can only be shown by the bench's scenarios, which compare results from a separately written model: the placement of each word, the order in which WK0 and WK1 are used, the rotation amounts, and the wrap-around of the sums. The same scenarios show that requests arriving while the unit is busy are ignored and that a reset cancels an operation in flight.

// File: rtl/sha512_rnd_pkg.sv
package sha512_rnd_pkg;
  localparam int QW    = 64;
  localparam int VEC_W = 4 * QW;
  localparam int WK_W  = 2 * QW;

  typedef logic [QW-1:0] qword_t;

  typedef struct packed {
    qword_t a, b, c, d, e, f, g, h;
  } work_t;

  function automatic qword_t rotr(qword_t x, int n);
    return (x >> n) | (x << (QW - n));
  endfunction

  function automatic qword_t big_sig0(qword_t x);
    return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
  endfunction

  function automatic qword_t big_sig1(qword_t x);
    return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
  endfunction

  function automatic qword_t maj(qword_t x, qword_t y, qword_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

  function automatic qword_t ch(qword_t x, qword_t y, qword_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic work_t one_round(work_t s, qword_t wk);
    qword_t t;
    work_t  n;
    t   = ch(s.e, s.f, s.g) + big_sig1(s.e) + wk + s.h;
    n.a = t + maj(s.a, s.b, s.c) + big_sig0(s.a);
    n.b = s.a;
    n.c = s.b;
    n.d = s.c;
    n.e = t + s.d;
    n.f = s.e;
    n.g = s.f;
    n.h = s.g;
    return n;
  endfunction

  function automatic work_t unpack_state(logic [VEC_W-1:0] abef, logic [VEC_W-1:0] cdgh);
    work_t s;
    s.a = abef[3*QW +: QW];
    s.b = abef[2*QW +: QW];
    s.e = abef[1*QW +: QW];
    s.f = abef[0*QW +: QW];
    s.c = cdgh[3*QW +: QW];
    s.d = cdgh[2*QW +: QW];
    s.g = cdgh[1*QW +: QW];
    s.h = cdgh[0*QW +: QW];
    return s;
  endfunction

  function automatic logic [VEC_W-1:0] pack_abef(work_t s);
    return {s.a, s.b, s.e, s.f};
  endfunction
endpackage

// File: rtl/sha512_rnd_step.sv
module sha512_rnd_step
  import sha512_rnd_pkg::*;
(
  input  work_t  st_i,
  input  qword_t wk_i,
  output work_t  st_o
);
  assign st_o = one_round(st_i, wk_i);
endmodule

// File: rtl/sha512_rnd_seq.sv
module sha512_rnd_seq
  import sha512_rnd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_i,
  input  work_t  st_i,
  input  qword_t wk0_i,
  input  qword_t wk1_i,
  output logic   busy_o,
  output logic   done_o,
  output work_t  st_o
);
  work_t  st_q;
  work_t  st_nx;
  qword_t wk0_q, wk1_q;
  logic   phase_q;
  logic   busy_q;
  logic   done_q;
  qword_t wk_sel;

  assign wk_sel = phase_q ? wk1_q : wk0_q;

  sha512_rnd_step u_step (
    .st_i (st_q),
    .wk_i (wk_sel),
    .st_o (st_nx)
  );

  always_ff @(posedge clk) begin
    if (start_i) begin
      st_q  <= st_i;
      wk0_q <= wk0_i;
      wk1_q <= wk1_i;
    end else if (busy_q) begin
      st_q <= st_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      done_q <= busy_q & phase_q;
      if (start_i) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b0;
      end else if (busy_q) begin
        phase_q <= ~phase_q;
        if (phase_q) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign st_o   = st_q;
endmodule

// File: rtl/sha512_rnd_comb.sv
module sha512_rnd_comb
  import sha512_rnd_pkg::*;
#(
  parameter int ROUNDS = 2
)(
  input  work_t              st_i,
  input  logic [WK_W-1:0]    wk_i,
  output work_t              st_o
);
  work_t chain [ROUNDS+1];

  assign chain[0] = st_i;

  for (genvar r = 0; r < ROUNDS; r++) begin : g_round
    sha512_rnd_step u_step (
      .st_i (chain[r]),
      .wk_i (wk_i[r*QW +: QW]),
      .st_o (chain[r+1])
    );
  end

  assign st_o = chain[ROUNDS];
endmodule

// File: rtl/sha512_dual_round.sv
module sha512_dual_round
  import sha512_rnd_pkg::*;
#(
  parameter bit ITERATIVE = 1'b1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] abef_in,
  input  logic [VEC_W-1:0] cdgh_in,
  input  logic [WK_W-1:0]  wk_in,
  output logic             busy,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_abef
);
  work_t st_in;
  work_t st_res;
  logic  accept_w;

  assign st_in    = unpack_state(abef_in, cdgh_in);
  assign accept_w = in_valid & in_ready;
  assign out_abef = pack_abef(st_res);

  if (ITERATIVE) begin : g_iter
    sha512_rnd_seq u_seq (
      .clk     (clk),
      .rst     (rst),
      .start_i (accept_w),
      .st_i    (st_in),
      .wk0_i   (wk_in[0 +: QW]),
      .wk1_i   (wk_in[QW +: QW]),
      .busy_o  (busy),
      .done_o  (out_valid),
      .st_o    (st_res)
    );
    assign in_ready = ~busy;
  end else begin : g_comb
    sha512_rnd_comb #(.ROUNDS(2)) u_comb (
      .st_i (st_in),
      .wk_i (wk_in),
      .st_o (st_res)
    );
    assign in_ready  = 1'b1;
    assign busy      = 1'b0;
    assign out_valid = in_valid;
  end
endmodule

// File: rtl/sha512_dual_round_chk.sv
module sha512_dual_round_chk #(
  parameter bit ITERATIVE = 1'b1,
  parameter int VW = 256
)(
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          busy,
  input logic          out_valid,
  input logic          accept,
  input logic [VW-1:0] out_abef
);
  if (ITERATIVE) begin : g_iter_chk
    assert_ready_low_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
      busy |-> !in_ready);

    assert_two_busy_then_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      accept |=> busy ##1 busy ##1 (out_valid && !busy));

    assert_valid_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

    assert_result_held_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
      (!busy && !accept) |=> $stable(out_abef));

    assert_reset_clears_control_R11: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!busy && !out_valid && in_ready));
  end else begin : g_comb_chk
    assert_comb_passthrough_R12: assert property (@(posedge clk) disable iff (rst)
      in_ready && !busy && (out_valid == in_valid));
  end
endmodule

bind sha512_dual_round sha512_dual_round_chk #(.ITERATIVE(ITERATIVE), .VW(sha512_rnd_pkg::VEC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .busy      (busy),
  .out_valid (out_valid),
  .accept    (accept_w),
  .out_abef  (out_abef)
);

// File: tb/sha512_dual_round_tb.sv
module sha512_dual_round_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [255:0] abef_in = '0;
  logic [255:0] cdgh_in = '0;
  logic [127:0] wk_in = '0;
  logic         in_ready, busy, out_valid;
  logic [255:0] out_abef;
  logic         c_ready, c_busy, c_valid;
  logic [255:0] c_abef;

  int n_checks = 0;
  int n_fails  = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #5 clk = ~clk;

  sha512_dual_round #(.ITERATIVE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .abef_in(abef_in), .cdgh_in(cdgh_in), .wk_in(wk_in),
    .busy(busy), .out_valid(out_valid), .out_abef(out_abef));

  sha512_dual_round #(.ITERATIVE(1'b0)) u_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(c_ready),
    .abef_in(abef_in), .cdgh_in(cdgh_in), .wk_in(wk_in),
    .busy(c_busy), .out_valid(c_valid), .out_abef(c_abef));

  function automatic logic [63:0] rr(logic [63:0] x, int n);
    logic [127:0] d;
    d = {x, x} >> n;
    return d[63:0];
  endfunction

  // independent model: v[0..7] = a..h
  function automatic logic [255:0] model(logic [255:0] p, logic [255:0] q, logic [127:0] w);
    logic [63:0] v [8];
    logic [63:0] t, s0, s1, mj, cf;
    v[0] = p[255:192]; v[1] = p[191:128]; v[4] = p[127:64]; v[5] = p[63:0];
    v[2] = q[255:192]; v[3] = q[191:128]; v[6] = q[127:64]; v[7] = q[63:0];
    for (int r = 0; r < 2; r++) begin
      s1 = rr(v[4], 41) ^ rr(v[4], 14) ^ rr(v[4], 18);
      s0 = rr(v[0], 39) ^ rr(v[0], 28) ^ rr(v[0], 34);
      cf = (v[4] & v[5]) | (~v[4] & v[6]);
      mj = (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
      t  = v[7] + cf + s1 + (r == 0 ? w[63:0] : w[127:64]);
      for (int k = 7; k > 0; k--) v[k] = v[k-1];
      v[4] = v[4] + t;
      v[0] = t + s0 + mj;
    end
    return {v[0], v[1], v[4], v[5]};
  endfunction

  function automatic logic [63:0] nxt(logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // full iterative operation plus combinational comparison; noise=1 drives other requests while busy
  task automatic run_op(input logic [255:0] p, input logic [255:0] q, input logic [127:0] w, input bit noise);
    logic [255:0] exp;
    exp = model(p, q, w);
    @(negedge clk);
    abef_in = p; cdgh_in = q; wk_in = w; in_valid = 1'b1;
    #1;
    chk(c_abef === exp, "R8 R12 comb result", c_abef, exp);
    chk(c_valid === 1'b1 && c_ready === 1'b1 && c_busy === 1'b0, "R12 comb control",
        {c_valid, c_ready, c_busy}, 3'b110);
    chk(in_ready === 1'b1, "R9 ready when idle", in_ready, 1);
    @(negedge clk);
    if (noise) begin
      abef_in = ~p; cdgh_in = q ^ 256'h5; wk_in = ~w;
    end else in_valid = 1'b0;
    chk(busy === 1'b1 && in_ready === 1'b0, "R9 busy cycle 1", {busy, in_ready}, 2'b10);
    @(negedge clk);
    chk(busy === 1'b1 && in_ready === 1'b0, "R9 busy cycle 2", {busy, in_ready}, 2'b10);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1 && busy === 1'b0, "R10 valid pulse", {out_valid, busy}, 2'b10);
    chk(out_abef === exp, noise ? "R9 R8 busy requests ignored" : "R8 iterative result", out_abef, exp);
    @(negedge clk);
    chk(out_valid === 1'b0, "R10 pulse one cycle", out_valid, 0);
    chk(out_abef === exp, "R10 result held", out_abef, exp);
  endtask

  initial begin
    #200000;
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [255:0] p, q;
    logic [127:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && out_valid === 1'b0 && in_ready === 1'b1, "R11 reset state",
        {busy, out_valid, in_ready}, 3'b001);

    // R3 R5 R8: zero state, WK0=5, WK1=0 -> B and F of the result both equal 5
    run_op('0, '0, {64'd0, 64'd5}, 1'b0);
    chk(out_abef[191:128] === 64'd5 && out_abef[63:0] === 64'd5, "R3 R5 WK0 used first",
        out_abef, {out_abef[255:192], 64'd5, out_abef[127:64], 64'd5});

    // R4 wrap-around with all ones
    run_op({256{1'b1}}, {256{1'b1}}, {128{1'b1}}, 1'b0);
    // R1 R2 single-word placements
    for (int k = 0; k < 8; k++) begin
      p = '0; q = '0;
      if (k < 4) p[k*64 +: 64] = 64'h8000_0000_0000_0001 << k;
      else       q[(k-4)*64 +: 64] = 64'h0123_4567_89AB_CDEF >> k;
      run_op(p, q, {64'h1, 64'h2}, 1'b0);
    end
    // R4 R6 R7 sweep of pseudo-random operands
    for (int n = 0; n < 40; n++) begin
      seed = nxt(seed); p[255:192] = seed; seed = nxt(seed); p[191:128] = seed;
      seed = nxt(seed); p[127:64] = seed;  seed = nxt(seed); p[63:0] = seed;
      seed = nxt(seed); q[255:192] = seed; seed = nxt(seed); q[191:128] = seed;
      seed = nxt(seed); q[127:64] = seed;  seed = nxt(seed); q[63:0] = seed;
      seed = nxt(seed); w[127:64] = seed;  seed = nxt(seed); w[63:0] = seed;
      run_op(p, q, w, n[0]);
    end

    // R11 reset cancels operation in flight
    @(negedge clk);
    abef_in = {4{64'hA5}}; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy === 1'b0 && out_valid === 1'b0 && in_ready === 1'b1, "R11 reset mid-operation",
        {busy, out_valid, in_ready}, 3'b001);
    @(negedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R11 no pulse after cancel", out_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule